// File: doc/BRIEF.md
# Relative Branch Decision Unit

This unit settles, for one relative branch at a time, whether control transfers and where execution goes next. It receives the address of the branch instruction, an 8-bit two's-complement displacement, a 5-bit condition selector, the four arithmetic status flags (negative, zero, overflow, carry), a 2-bit instruction-length class, and, for branches that test bits in memory, the tested byte and a mask. It produces a taken indication, the branch target, and the fall-through address of the next sequential instruction.

Two families of conditions share one selector. The flag family covers the codes below 16. Codes are paired, and the odd member of each pair is the exact complement of the even member. The pairs cover always/never, unsigned higher/lower-or-same, carry clear/set, zero clear/set, overflow clear/set, negative clear/set, and signed greater-or-equal/less-than and greater-than/less-or-equal. The memory family covers codes 16 and 17. These compare the tested byte against the mask. The length class adds the instruction-length term to both address outputs, because bit-test branches are longer than plain ones and depend on the index register used.

All outputs are registered. Inputs presented before a rising clock edge appear on the outputs after that edge.

Top module: `bcu_branch_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the edge clears `taken_o`, `target_o` and `fall_o` to zero.
- R2: Outputs change only at a rising edge, one cycle after the inputs are sampled. A change of input between edges leaves the outputs unchanged.
- R3: Code 0 is always taken. Code 1 and codes 18 to 31 are never taken.
- R4: Single-flag codes are as follows: 4 is taken when C=0 (also used as unsigned higher-or-same), 5 when C=1 (also used as unsigned lower), 6 when Z=0, 7 when Z=1, 8 when V=0, 9 when V=1, 10 when N=0 and 11 when N=1.
- R5: Code 2 (unsigned higher) is taken when C=0 and Z=0. Code 3 (unsigned lower-or-same) is taken when C=1 or Z=1.
- R6: The signed codes are as follows: 12 is taken when N equals V, 13 when N differs from V, 14 when Z=0 and N equals V, and 15 when Z=1 or N differs from V.
- R7: Code 16 is taken when every bit that is 1 in `mask_i` is also 1 in `byte_i`. Code 17 is taken when every such bit is 0 in `byte_i`. An all-zero mask makes both codes taken.
- R8: The length term T is 2 for class 0 (plain branch), 4 for class 1 (bit test indexed by X), 5 for class 2 (bit test indexed by Y) and 4 for class 3 (bit test with direct address).
- R9: `fall_o` equals `pc_i + T` modulo 2^16.
- R10: `target_o` equals `pc_i + T` plus the sign-extended `disp_i`, modulo 2^16. For example, address $E010, class 0 and displacement $F6 give fall-through $E012 and target $E008.
- R11: Flag codes ignore `byte_i` and `mask_i`. Memory codes 16 and 17 ignore the flags. Address outputs are the same for every condition code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_i | input | 16 | Address of the branch instruction |
| disp_i | input | 8 | Two's-complement branch displacement |
| cond_i | input | 5 | Condition selector (see R3 to R7) |
| flags_i | input | 4 | Status flags ordered {N, Z, V, C} |
| len_i | input | 2 | Instruction-length class (see R8) |
| byte_i | input | 8 | Tested memory byte for codes 16 and 17 |
| mask_i | input | 8 | Bit-select mask for codes 16 and 17 |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Branch destination address |
| fall_o | output | 16 | Next sequential instruction address |

## Verification
The bench builds the unit with its default parameters: 16-bit addresses, 8-bit displacement and byte, and length terms 2, 4, 5 and 4. At these widths every condition code can be swept against all sixteen flag combinations. Both memory codes can be swept against every byte value under sixteen masks, including the empty and full masks. Every displacement can be swept under every length class at addresses near zero, in the middle of the range and just below the top of the address space, so wrap-around and negative offsets come within reach.

// File: rtl/bcu_pkg.sv
// Package: shared widths, condition selector values, length classes and
// the flag bundle for the branch decision unit.
// Assumes flags are delivered as {N, Z, V, C}.
package bcu_pkg;

    localparam int COND_W = 5;
    localparam int LEN_W  = 2;

    // Condition selector values; bit 0 of a flag code inverts its partner.
    localparam logic [COND_W-1:0] CC_ALWAYS = 5'd0;
    localparam logic [COND_W-1:0] CC_NEVER  = 5'd1;
    localparam logic [COND_W-1:0] CC_FLAG_LIMIT = 5'd16;
    localparam logic [COND_W-1:0] CC_BITS_SET   = 5'd16;
    localparam logic [COND_W-1:0] CC_BITS_CLR   = 5'd17;

    // Instruction-length classes.
    localparam logic [LEN_W-1:0] LC_PLAIN  = 2'd0;
    localparam logic [LEN_W-1:0] LC_IDX_X  = 2'd1;
    localparam logic [LEN_W-1:0] LC_IDX_Y  = 2'd2;
    localparam logic [LEN_W-1:0] LC_DIRECT = 2'd3;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/bcu_flag_eval.sv
// Flag condition evaluator: resolves the sixteen flag-based codes.
// Even codes hold the base condition, odd codes its complement.
// Assumes only the low four selector bits reach it.
module bcu_flag_eval
    import bcu_pkg::*;
(
    input  logic [3:0] sel_i,
    input  flags_t     flags_i,
    output logic       ok_o
);

    logic [7:0] base;
    logic       sign_agree;

    // Base conditions indexed by sel_i[3:1].
    always_comb begin
        sign_agree = (flags_i.n == flags_i.v);
        base[0] = 1'b1;                          // always
        base[1] = !flags_i.c && !flags_i.z;      // unsigned higher
        base[2] = !flags_i.c;                    // carry clear
        base[3] = !flags_i.z;                    // not zero
        base[4] = !flags_i.v;                    // no overflow
        base[5] = !flags_i.n;                    // non-negative
        base[6] = sign_agree;                    // signed greater or equal
        base[7] = sign_agree && !flags_i.z;      // signed greater
    end

    // Select the pair and apply the inversion bit.
    always_comb begin
        ok_o = base[sel_i[3:1]] ^ sel_i[0];
    end

endmodule

// File: rtl/bcu_bit_eval.sv
// Mask test evaluator: reports whether every masked bit of the byte is
// set and whether every masked bit is clear. An empty mask satisfies both.
module bcu_bit_eval #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] mask_i,
    output logic              all_set_o,
    output logic              all_clr_o
);

    logic [BYTE_W-1:0] set_ok;
    logic [BYTE_W-1:0] clr_ok;

    // Per-bit qualification; unmasked bits always qualify.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign set_ok[i] = !mask_i[i] || byte_i[i];
        assign clr_ok[i] = !mask_i[i] || !byte_i[i];
    end

    // Reduce across the byte.
    always_comb begin
        all_set_o = &set_ok;
        all_clr_o = &clr_ok;
    end

endmodule

// File: rtl/bcu_addr_gen.sv
// Address generator: picks the length term from the class and forms the
// fall-through and target addresses, wrapping modulo 2^ADDR_W.
module bcu_addr_gen
    import bcu_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DISP_W   = 8,
    parameter int T_PLAIN  = 2,
    parameter int T_IDX_X  = 4,
    parameter int T_IDX_Y  = 5,
    parameter int T_DIRECT = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] fall_o,
    output logic [ADDR_W-1:0] target_o
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] len_term;
    logic [ADDR_W-1:0] disp_ext;

    // Length term for the instruction class.
    always_comb begin
        case (len_i)
            LC_PLAIN:  len_term = ADDR_W'(T_PLAIN);
            LC_IDX_X:  len_term = ADDR_W'(T_IDX_X);
            LC_IDX_Y:  len_term = ADDR_W'(T_IDX_Y);
            default:   len_term = ADDR_W'(T_DIRECT);
        endcase
    end

    // Sign-extend displacement and add.
    always_comb begin
        disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
        fall_o   = pc_i + len_term;
        target_o = fall_o + disp_ext;
    end

endmodule

// File: rtl/bcu_branch_unit.sv
// Relative branch decision unit (top). Chooses between flag and mask
// evaluation by selector range, registers the decision and addresses.
// Assumes synchronous active-low reset; one cycle from input to output.
module bcu_branch_unit
    import bcu_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DISP_W   = 8,
    parameter int BYTE_W   = 8,
    parameter int T_PLAIN  = 2,
    parameter int T_IDX_X  = 4,
    parameter int T_IDX_Y  = 5,
    parameter int T_DIRECT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [4:0]        cond_i,
    input  logic [3:0]        flags_i,
    input  logic [1:0]        len_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] mask_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o,
    output logic [ADDR_W-1:0] fall_o
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic              flag_ok;
    logic              all_set;
    logic              all_clr;
    logic              taken_d;
    logic [ADDR_W-1:0] fall_d;
    logic [ADDR_W-1:0] target_d;

    bcu_flag_eval u_flag (
        .sel_i   (cond_i[3:0]),
        .flags_i (flags_t'(flags_i)),
        .ok_o    (flag_ok)
    );

    bcu_bit_eval #(.BYTE_W(BYTE_W)) u_bits (
        .byte_i    (byte_i),
        .mask_i    (mask_i),
        .all_set_o (all_set),
        .all_clr_o (all_clr)
    );

    bcu_addr_gen #(
        .ADDR_W(ADDR_W), .DISP_W(DISP_W),
        .T_PLAIN(T_PLAIN), .T_IDX_X(T_IDX_X),
        .T_IDX_Y(T_IDX_Y), .T_DIRECT(T_DIRECT)
    ) u_addr (
        .pc_i     (pc_i),
        .disp_i   (disp_i),
        .len_i    (len_i),
        .fall_o   (fall_d),
        .target_o (target_d)
    );

    // Route the selector to the flag or mask result; unused codes never take.
    always_comb begin
        if (cond_i < CC_FLAG_LIMIT)     taken_d = flag_ok;
        else if (cond_i == CC_BITS_SET) taken_d = all_set;
        else if (cond_i == CC_BITS_CLR) taken_d = all_clr;
        else                            taken_d = 1'b0;
    end

    // Output registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o  <= 1'b0;
            target_o <= '0;
            fall_o   <= '0;
        end else begin
            taken_o  <= taken_d;
            target_o <= target_d;
            fall_o   <= fall_d;
        end
    end

    // Always code takes, never code does not.
    p_always_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == CC_ALWAYS) |=> taken_o);
    p_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == CC_NEVER) |=> !taken_o);

    // Carry-clear code follows the inverted carry flag.
    p_carry_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 5'd4) |=> (taken_o == !$past(flags_i[0])));

    // Full mask match under the bit-set code forces a taken branch.
    p_mask_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == CC_BITS_SET && (byte_i & mask_i) == mask_i) |=> taken_o);

    // Fall-through lies two to five bytes past the branch address.
    p_fall_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((fall_o - $past(pc_i)) >= ADDR_W'(2)
                && (fall_o - $past(pc_i)) <= ADDR_W'(5)));

    // Target and fall-through differ by the sign-extended displacement.
    p_target_disp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((target_o - fall_o)
                == {{EXT_W{$past(disp_i[DISP_W-1])}}, $past(disp_i)}));

endmodule

// File: tb/sim_bcu_branch_unit.sv
module sim_bcu_branch_unit;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] pc_i;
    logic [7:0]  disp_i;
    logic [4:0]  cond_i;
    logic [3:0]  flags_i;
    logic [1:0]  len_i;
    logic [7:0]  byte_i;
    logic [7:0]  mask_i;
    logic        taken_o;
    logic [15:0] target_o;
    logic [15:0] fall_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bcu_branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .disp_i(disp_i),
        .cond_i(cond_i), .flags_i(flags_i), .len_i(len_i),
        .byte_i(byte_i), .mask_i(mask_i), .taken_o(taken_o),
        .target_o(target_o), .fall_o(fall_o)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cond %0d flags %b byte %h mask %h pc %h disp %h len %0d)",
                     req, act, exp, cond_i, flags_i, byte_i, mask_i, pc_i, disp_i, len_i);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Expected decision from the requirement text.
    function automatic bit exp_taken(int c, logic [3:0] f, logic [7:0] b, logic [7:0] m);
        bit n = f[3], z = f[2], v = f[1], cy = f[0];
        case (c)
            0:  return 1;                       // R3
            1:  return 0;                       // R3
            2:  return (cy == 0) && (z == 0);   // R5
            3:  return (cy == 1) || (z == 1);   // R5
            4:  return cy == 0;                 // R4
            5:  return cy == 1;                 // R4
            6:  return z == 0;                  // R4
            7:  return z == 1;                  // R4
            8:  return v == 0;                  // R4
            9:  return v == 1;                  // R4
            10: return n == 0;                  // R4
            11: return n == 1;                  // R4
            12: return n == v;                  // R6
            13: return n != v;                  // R6
            14: return (z == 0) && (n == v);    // R6
            15: return (z == 1) || (n != v);    // R6
            16: return (b & m) == m;            // R7
            17: return (b & m) == 8'h00;        // R7
            default: return 0;                  // R3
        endcase
    endfunction

    function automatic string req_of(int c);
        if (c < 2 || c > 17) return "R3";
        if (c < 4)           return "R5";
        if (c < 12)          return "R4";
        if (c < 16)          return "R6";
        return "R7";
    endfunction

    function automatic int len_term(int l);
        case (l)                                // R8
            0: return 2;
            1: return 4;
            2: return 5;
            default: return 4;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        pc_i = 16'h1234; disp_i = 8'h10; cond_i = 5'd0; flags_i = 4'hF;
        len_i = 2'd1; byte_i = 8'hFF; mask_i = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1", taken_o, 0);
        check("R1", target_o, 0);
        check("R1", fall_o, 0);
        rst_n = 1'b1;

        // R2: a change between edges does not reach the outputs
        cond_i = 5'd1;
        @(negedge clk);
        check("R2", taken_o, 0);
        cond_i = 5'd0;
        #1;
        check("R2", taken_o, 0);
        @(negedge clk);
        check("R2", taken_o, 1);

        // Flag sweep over all codes; byte and mask vary (R11)
        pc_i = 16'h4000; disp_i = 8'h20; len_i = 2'd0;
        for (int c = 0; c < 32; c++) begin
            for (int f = 0; f < 16; f++) begin
                cond_i = 5'(c); flags_i = 4'(f);
                byte_i = 8'(c * 13 + f * 7); mask_i = 8'(f * 29 + c);
                @(negedge clk);
                check({req_of(c), " R11"}, taken_o,
                      exp_taken(c, flags_i, byte_i, mask_i));
                check("R11", target_o, 16'h4022);
            end
        end

        // Mask sweep for codes 16 and 17; flags vary (R7, R11)
        for (int c = 16; c < 18; c++) begin
            for (int k = 0; k < 16; k++) begin
                for (int b = 0; b < 256; b++) begin
                    cond_i = 5'(c); byte_i = 8'(b);
                    mask_i = (k == 0) ? 8'h00 : (k == 15) ? 8'hFF : 8'(k * 8'h1D + 8'h05);
                    flags_i = 4'(b ^ k);
                    @(negedge clk);
                    check("R7 R11", taken_o, exp_taken(c, flags_i, byte_i, mask_i));
                end
            end
        end

        // Address sweep over lengths and displacements (R8, R9, R10)
        cond_i = 5'd0;
        for (int p = 0; p < 4; p++) begin
            for (int l = 0; l < 4; l++) begin
                for (int d = 0; d < 256; d++) begin
                    int base, sd;
                    base = (p == 0) ? 16'h0000 : (p == 1) ? 16'hE010 :
                           (p == 2) ? 16'hFFFE : 16'h7FF0;
                    sd = (d >= 128) ? d - 256 : d;
                    pc_i = 16'(base); len_i = 2'(l); disp_i = 8'(d);
                    @(negedge clk);
                    check("R8 R9", fall_o, (base + len_term(l)) & 16'hFFFF);
                    check("R10", target_o, (base + len_term(l) + sd) & 16'hFFFF);
                end
            end
        end

        // R10 worked example
        pc_i = 16'hE010; len_i = 2'd0; disp_i = 8'hF6; cond_i = 5'd7; flags_i = 4'b0100;
        @(negedge clk);
        check("R10", fall_o, 16'hE012);
        check("R10", target_o, 16'hE008);
        check("R4", taken_o, 1);

        // R1 again: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", taken_o, 0);
        check("R1", fall_o, 0);
        check("R1", target_o, 0);

        finish_run();
    end

endmodule